// File: doc/BRIEF.md
# PLL Step-Response Meter

This block is a digital test unit that sits beside the feedback divider of an integer-N phase-locked loop. It runs on the VCO clock. On request it disturbs the loop by a known phase step: for exactly one feedback period it hands the divider a different divisor, either larger or smaller than the programmed one. It then watches how the loop pulls back, with no outside instrument.

A one-bit early/late decision is taken at every reference event. The block counts VCO cycles from the start of the step to the first reversal of that decision, which gives the crossover time. Over the same interval it keeps the largest divider count sampled at reference events, which gives the peak overshoot. Crossover time tracks loop bandwidth, and peak overshoot tracks jitter peaking. Software outside the block turns these numbers into calibration decisions.

The reference clock arrives asynchronously and passes through a two-flop synchronizer before any use. The feedback divider output is already in the VCO domain. Results stay on the outputs until the next accepted start.

Top module: `pll_step_meter`

## Requirements
- R1: After reset, `overrideEn`, `done` and `overflow` are low, and `crossCount` and `maxOvershoot` are zero.
- R2: A start request is accepted only while the unit is idle or done, and only when `divisorN` is at least 8. A start request with a smaller divisor is ignored: no override is issued and `done` stays low.
- R3: After an accepted start, the unit waits for a rising edge of `fbLevel`. On the clock edge that takes that edge, it raises `overrideEn` with `divOverride` equal to `divisorN + stepSize` when `stepDir` is 1, or `divisorN - stepSize` when `stepDir` is 0. It drops `overrideEn` on the clock edge that takes the next rising edge of `fbLevel`.
- R4: `refIn` passes through two flops. A rising transition of `refIn` becomes a reference event that is acted on at the third rising clock edge after the transition.
- R5: At each reference event after the override period, the decision is the level of `fbLevel`. The first two such events are ignored. The third sets the baseline decision.
- R6: `crossCount` equals the number of clock cycles from the edge that raised `overrideEn` to the edge that takes the first later reference event whose decision differs from the baseline.
- R7: `maxOvershoot` is cleared when the step begins. It then holds the largest `divCount` value sampled at reference events after the override period. This covers blanked events and events after crossover, up to the end of the measurement.
- R8: After crossover, the measurement ends once `settleCycles` further reference events have been taken. `done` rises on the following clock edge.
- R9: If `crossCount` reaches 1023 with no reversal seen, it stops at 1023, `overflow` is set and `done` rises.
- R10: While `done` is high, results do not change until a start is accepted. An accepted start clears `done` and `overflow`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | VCO-domain clock |
| rstN | input | 1 | Active-low asynchronous reset |
| startReq | input | 1 | Request to run one measurement |
| divisorN | input | 6 | Programmed feedback divisor |
| stepSize | input | 2 | Step size in VCO cycles (1 to 3) |
| stepDir | input | 1 | 1 lengthens the override period, 0 shortens it |
| settleCycles | input | 4 | Reference events to observe after crossover |
| refIn | input | 1 | Reference clock, asynchronous |
| fbLevel | input | 1 | Feedback divider output level |
| divCount | input | 6 | Current feedback divider count |
| overrideEn | output | 1 | Divider must use `divOverride` for the current period |
| divOverride | output | 7 | One-shot divisor value |
| crossCount | output | 10 | Crossover time in VCO cycles |
| maxOvershoot | output | 6 | Largest sampled divider count |
| done | output | 1 | Measurement finished, results valid |
| overflow | output | 1 | Crossover counter saturated |

## Verification
The properties assume three things. First, `divisorN`, `stepSize` and `stepDir` stay constant while a measurement runs. Second, `stepSize` is nonzero. Third, every `refIn` pulse stays high and then low for at least two clock cycles each, so the synchronizer sees every edge. The bench changes these settings only when the unit is idle or done, and it holds `refIn` high and low for three cycles per pulse. It also holds the decision level and `divCount` steady for the whole window around each event. This makes the edge on which every sample is taken fixed and known.

// File: rtl/psm_pkg.sv
package psm_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARM,
    ST_STEP,
    ST_MEAS,
    ST_DONE
  } stateT;

  // strobes from control to datapath
  typedef struct packed {
    logic accept;     // start taken this cycle
    logic stepBegin;  // feedback edge that opens the override period
    logic inStep;     // override period active
    logic inMeas;     // measurement phase
    logic inDone;     // results frozen
  } ctrlStrobeT;

  // status from datapath to control
  typedef struct packed {
    logic crossSat;
    logic settleDone;
  } dpStatusT;

endpackage

// File: rtl/psm_edge_sync.sv
module psm_edge_sync #(
  parameter int STAGES  = 2,
  parameter bit RISING  = 1'b1
) (
  input  logic clk,
  input  logic rstN,
  input  logic sigIn,
  output logic evt
);

  logic syncOut;
  logic prevQ;

  generate
    if (STAGES > 0) begin : g_sync
      logic [STAGES-1:0] ffQ;
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) ffQ[i] <= 1'b0;
          else if (i == 0) ffQ[i] <= sigIn;
          else ffQ[i] <= ffQ[(i == 0) ? 0 : i-1];
        end
      end
      assign syncOut = ffQ[STAGES-1];
    end else begin : g_direct
      assign syncOut = sigIn;
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevQ <= 1'b0;
    else prevQ <= syncOut;
  end

  generate
    if (RISING) begin : g_rise
      assign evt = syncOut & ~prevQ;
    end else begin : g_fall
      assign evt = ~syncOut & prevQ;
    end
  endgenerate

endmodule

// File: rtl/psm_ctrl.sv
module psm_ctrl
  import psm_pkg::*;
#(
  parameter int DIV_W   = 6,
  parameter int MIN_DIV = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  input  logic [DIV_W-1:0] divisorN,
  input  logic             fbRise,
  input  dpStatusT         status,
  output ctrlStrobeT       strobe
);

  localparam logic [DIV_W-1:0] MIN_DIV_V = DIV_W'(MIN_DIV);

  stateT stateQ, stateD;
  logic  divOk;

  assign divOk = (divisorN >= MIN_DIV_V);

  always_comb begin
    strobe.accept    = startReq && divOk && (stateQ == ST_IDLE || stateQ == ST_DONE);
    strobe.stepBegin = (stateQ == ST_ARM) && fbRise;
    strobe.inStep    = (stateQ == ST_STEP);
    strobe.inMeas    = (stateQ == ST_MEAS);
    strobe.inDone    = (stateQ == ST_DONE);
  end

  always_comb begin
    stateD = stateQ;
    case (stateQ)
      ST_IDLE: if (strobe.accept) stateD = ST_ARM;
      ST_ARM:  if (fbRise) stateD = ST_STEP;
      ST_STEP: if (fbRise) stateD = ST_MEAS;
      ST_MEAS: if (status.settleDone || status.crossSat) stateD = ST_DONE;
      ST_DONE: if (strobe.accept) stateD = ST_ARM;
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_IDLE;
    else stateQ <= stateD;
  end

endmodule

// File: rtl/psm_datapath.sv
module psm_datapath
  import psm_pkg::*;
#(
  parameter int DIV_W    = 6,
  parameter int STEP_W   = 2,
  parameter int CNT_W    = 10,
  parameter int SETTLE_W = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrobeT          strobe,
  input  logic                refEvt,
  input  logic                fbLevel,
  input  logic [DIV_W-1:0]    divCount,
  input  logic [DIV_W-1:0]    divisorN,
  input  logic [STEP_W-1:0]   stepSize,
  input  logic                stepDir,
  input  logic [SETTLE_W-1:0] settleCycles,
  output dpStatusT            status,
  output logic [DIV_W:0]      divOverride,
  output logic [CNT_W-1:0]    crossCount,
  output logic [DIV_W-1:0]    maxOvershoot,
  output logic                overflow
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0]    crossCntQ;
  logic                crossFoundQ;
  logic [1:0]          blankCntQ;
  logic                baseSignQ;
  logic [DIV_W-1:0]    maxQ;
  logic [SETTLE_W-1:0] settleCntQ;
  logic                overflowQ;
  logic                active;
  logic                measEvt;

  assign active  = strobe.inStep | strobe.inMeas;
  assign measEvt = strobe.inMeas & refEvt;

  // one-shot divisor, lengthened or shortened by the step
  assign divOverride = stepDir ? ({1'b0, divisorN} + (DIV_W+1)'(stepSize))
                               : ({1'b0, divisorN} - (DIV_W+1)'(stepSize));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      crossCntQ   <= '0;
      crossFoundQ <= 1'b0;
      blankCntQ   <= '0;
      baseSignQ   <= 1'b0;
      maxQ        <= '0;
      settleCntQ  <= '0;
    end else if (strobe.stepBegin) begin
      crossCntQ   <= '0;
      crossFoundQ <= 1'b0;
      blankCntQ   <= '0;
      baseSignQ   <= 1'b0;
      maxQ        <= '0;
      settleCntQ  <= '0;
    end else begin
      if (active && !crossFoundQ && crossCntQ != CNT_MAX)
        crossCntQ <= crossCntQ + 1'b1;
      if (measEvt) begin
        if (divCount > maxQ) maxQ <= divCount;
        if (blankCntQ < 2'd2) begin
          blankCntQ <= blankCntQ + 1'b1;
        end else if (blankCntQ == 2'd2) begin
          baseSignQ <= fbLevel;
          blankCntQ <= 2'd3;
        end else if (!crossFoundQ) begin
          if (fbLevel != baseSignQ) crossFoundQ <= 1'b1;
        end else begin
          settleCntQ <= settleCntQ + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) overflowQ <= 1'b0;
    else if (strobe.accept) overflowQ <= 1'b0;
    else if (status.crossSat) overflowQ <= 1'b1;
  end

  assign status.crossSat   = strobe.inMeas && !crossFoundQ && (crossCntQ == CNT_MAX);
  assign status.settleDone = strobe.inMeas && crossFoundQ && (settleCntQ >= settleCycles);

  assign crossCount   = crossCntQ;
  assign maxOvershoot = maxQ;
  assign overflow     = overflowQ;

endmodule

// File: rtl/pll_step_meter.sv
module pll_step_meter
  import psm_pkg::*;
#(
  parameter int DIV_W       = 6,
  parameter int STEP_W      = 2,
  parameter int CNT_W       = 10,
  parameter int SETTLE_W    = 4,
  parameter int MIN_DIV     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                startReq,
  input  logic [DIV_W-1:0]    divisorN,
  input  logic [STEP_W-1:0]   stepSize,
  input  logic                stepDir,
  input  logic [SETTLE_W-1:0] settleCycles,
  input  logic                refIn,
  input  logic                fbLevel,
  input  logic [DIV_W-1:0]    divCount,
  output logic                overrideEn,
  output logic [DIV_W:0]      divOverride,
  output logic [CNT_W-1:0]    crossCount,
  output logic [DIV_W-1:0]    maxOvershoot,
  output logic                done,
  output logic                overflow
);

  ctrlStrobeT strobe;
  dpStatusT   status;
  logic       refEvt;
  logic       fbRise;

  psm_edge_sync #(.STAGES(SYNC_STAGES), .RISING(1'b1)) i_refSync (
    .clk(clk), .rstN(rstN), .sigIn(refIn), .evt(refEvt)
  );

  psm_edge_sync #(.STAGES(0), .RISING(1'b1)) i_fbEdge (
    .clk(clk), .rstN(rstN), .sigIn(fbLevel), .evt(fbRise)
  );

  psm_ctrl #(.DIV_W(DIV_W), .MIN_DIV(MIN_DIV)) i_ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .divisorN(divisorN),
    .fbRise(fbRise), .status(status), .strobe(strobe)
  );

  psm_datapath #(
    .DIV_W(DIV_W), .STEP_W(STEP_W), .CNT_W(CNT_W), .SETTLE_W(SETTLE_W)
  ) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .refEvt(refEvt),
    .fbLevel(fbLevel), .divCount(divCount), .divisorN(divisorN),
    .stepSize(stepSize), .stepDir(stepDir), .settleCycles(settleCycles),
    .status(status), .divOverride(divOverride), .crossCount(crossCount),
    .maxOvershoot(maxOvershoot), .overflow(overflow)
  );

  assign overrideEn = strobe.inStep;
  assign done       = strobe.inDone;

endmodule

// File: rtl/psm_checker.sv
module psm_checker #(
  parameter int DIV_W   = 6,
  parameter int STEP_W  = 2,
  parameter int CNT_W   = 10,
  parameter int MIN_DIV = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              startReq,
  input logic [DIV_W-1:0]  divisorN,
  input logic [STEP_W-1:0] stepSize,
  input logic              stepDir,
  input logic              overrideEn,
  input logic [DIV_W:0]    divOverride,
  input logic [CNT_W-1:0]  crossCount,
  input logic [DIV_W-1:0]  maxOvershoot,
  input logic              done,
  input logic              overflow
);

  localparam logic [DIV_W-1:0] MIN_DIV_V = DIV_W'(MIN_DIV);
  localparam logic [CNT_W-1:0] CNT_MAX   = '1;

  // R10
  hold_results_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && !startReq) |=> ($stable(crossCount) && $stable(maxOvershoot) && $stable(overflow)));

  // R9
  overflow_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    overflow |-> done);

  // R9
  overflow_sat_chk: assert property (@(posedge clk) disable iff (!rstN)
    overflow |-> (crossCount == CNT_MAX));

  // R2
  override_divok_chk: assert property (@(posedge clk) disable iff (!rstN)
    overrideEn |-> (divisorN >= MIN_DIV_V));

  // R3
  override_value_chk: assert property (@(posedge clk) disable iff (!rstN)
    overrideEn |-> (stepDir ? (divOverride == {1'b0, divisorN} + (DIV_W+1)'(stepSize))
                            : (divOverride == {1'b0, divisorN} - (DIV_W+1)'(stepSize))));

  // R3
  override_not_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    overrideEn |-> !done);

endmodule

bind pll_step_meter psm_checker #(
  .DIV_W(DIV_W), .STEP_W(STEP_W), .CNT_W(CNT_W), .MIN_DIV(MIN_DIV)
) i_psmChecker (
  .clk(clk), .rstN(rstN), .startReq(startReq), .divisorN(divisorN),
  .stepSize(stepSize), .stepDir(stepDir), .overrideEn(overrideEn),
  .divOverride(divOverride), .crossCount(crossCount),
  .maxOvershoot(maxOvershoot), .done(done), .overflow(overflow)
);

// File: tb/test_pll_step_meter.sv
module test_pll_step_meter;

  localparam int CLK_PERIOD = 10;
  localparam int N_EVT      = 12;

  typedef struct packed {
    logic [5:0]  div;
    logic [1:0]  step;
    logic        dir;
    logic [3:0]  settle;
    logic [11:0] dec;
    logic [5:0]  seed;
  } vecT;

  localparam vecT VECS [6] = '{
    '{6'd16, 2'd1, 1'b1, 4'd2, 12'h0F0, 6'd3},
    '{6'd8,  2'd3, 1'b0, 4'd1, 12'h008, 6'd5},
    '{6'd63, 2'd2, 1'b1, 4'd3, 12'h07F, 6'd40},
    '{6'd20, 2'd3, 1'b1, 4'd0, 12'h3E4, 6'd11},
    '{6'd33, 2'd1, 1'b0, 4'd3, 12'h300, 6'd30},
    '{6'd9,  2'd2, 1'b0, 4'd5, 12'h020, 6'd0}
  };

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       startReq = 1'b0;
  logic [5:0] divisorN = 6'd16;
  logic [1:0] stepSize = 2'd1;
  logic       stepDir = 1'b1;
  logic [3:0] settleCycles = 4'd0;
  logic       refIn = 1'b0;
  logic       fbLevel = 1'b0;
  logic [5:0] divCount = 6'd0;
  logic       overrideEn;
  logic [6:0] divOverride;
  logic [9:0] crossCount;
  logic [5:0] maxOvershoot;
  logic       done;
  logic       overflow;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pll_step_meter i_pll_step_meter (
    .clk(clk), .rstN(rstN), .startReq(startReq), .divisorN(divisorN),
    .stepSize(stepSize), .stepDir(stepDir), .settleCycles(settleCycles),
    .refIn(refIn), .fbLevel(fbLevel), .divCount(divCount),
    .overrideEn(overrideEn), .divOverride(divOverride),
    .crossCount(crossCount), .maxOvershoot(maxOvershoot),
    .done(done), .overflow(overflow)
  );

  task automatic negs(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Starts a run and passes the override period; returns the cycle before the step edge.
  task automatic runStep(input logic [5:0] n, input logic [1:0] s, input logic d,
                         input logic [3:0] st, output int c0);
    int expOvr;
    divisorN = n; stepSize = s; stepDir = d; settleCycles = st;
    fbLevel = 1'b0; startReq = 1'b1;
    negs(1);
    startReq = 1'b0;
    negs(1);
    fbLevel = 1'b1;
    c0 = cyc;
    negs(1);
    expOvr = d ? int'(n) + int'(s) : int'(n) - int'(s);
    check(overrideEn == 1'b1, "R3 override on", int'(overrideEn), 1);
    check(int'(divOverride) == expOvr, "R3 override value", int'(divOverride), expOvr);
    negs(1);
    fbLevel = 1'b0;
    negs(2);
    fbLevel = 1'b1;
    negs(1);
    check(overrideEn == 1'b0, "R3 override off after one period", int'(overrideEn), 0);
  endtask

  task automatic refPulse(input logic dec, input logic [5:0] cnt, output int c);
    fbLevel = dec; divCount = cnt; refIn = 1'b1;
    c = cyc;
    negs(3);
    refIn = 1'b0;
    negs(3);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int c0;
    int cEvt;
    negs(3);
    rstN = 1'b1;
    negs(1);
    // R1 reset state
    check(overrideEn == 1'b0, "R1 overrideEn", int'(overrideEn), 0);
    check(done == 1'b0, "R1 done", int'(done), 0);
    check(overflow == 1'b0, "R1 overflow", int'(overflow), 0);
    check(crossCount == 10'd0, "R1 crossCount", int'(crossCount), 0);
    check(maxOvershoot == 6'd0, "R1 maxOvershoot", int'(maxOvershoot), 0);

    // R2 divisor below 8 is rejected
    divisorN = 6'd7; fbLevel = 1'b0; startReq = 1'b1;
    negs(1);
    startReq = 1'b0;
    negs(1);
    fbLevel = 1'b1;
    negs(2);
    check(overrideEn == 1'b0, "R2 reject N=7 override", int'(overrideEn), 0);
    fbLevel = 1'b0;
    negs(3);
    fbLevel = 1'b1;
    negs(3);
    check(overrideEn == 1'b0 && done == 1'b0, "R2 reject N=7 no run",
          int'({overrideEn, done}), 0);

    // table of runs
    foreach (VECS[v]) begin
      vecT vc;
      int cnts[N_EVT];
      int cIdx;
      int lastIdx;
      int expMax;
      int expCross;
      vc = VECS[v];
      for (int i = 0; i < N_EVT; i++) cnts[i] = (int'(vc.seed) + 7*i) % int'(vc.div);
      cIdx = -1;
      for (int i = 3; i < N_EVT; i++)
        if (cIdx < 0 && vc.dec[i] != vc.dec[2]) cIdx = i;
      lastIdx = cIdx + int'(vc.settle);
      expMax = 0;
      for (int i = 0; i <= lastIdx; i++) if (cnts[i] > expMax) expMax = cnts[i];
      runStep(vc.div, vc.step, vc.dir, vc.settle, c0);
      expCross = 0;
      for (int i = 0; i < N_EVT; i++) begin
        if (done) break;
        refPulse(vc.dec[i], 6'(cnts[i]), cEvt);
        if (i == cIdx) expCross = cEvt - c0 + 2;
      end
      check(done == 1'b1, "R8 done after settle events", int'(done), 1);
      check(int'(crossCount) == expCross, "R4 R5 R6 crossover count",
            int'(crossCount), expCross);
      check(int'(maxOvershoot) == expMax, "R7 peak divider count",
            int'(maxOvershoot), expMax);
      check(overflow == 1'b0, "R9 no overflow", int'(overflow), 0);
    end

    // R10 results frozen while done
    begin
      int holdCross;
      int holdMax;
      holdCross = int'(crossCount);
      holdMax = int'(maxOvershoot);
      refPulse(1'b0, 6'd62, cEvt);
      refPulse(1'b1, 6'd63, cEvt);
      refPulse(1'b0, 6'd61, cEvt);
      check(int'(crossCount) == holdCross, "R10 crossCount held", int'(crossCount), holdCross);
      check(int'(maxOvershoot) == holdMax, "R10 maxOvershoot held", int'(maxOvershoot), holdMax);
      check(done == 1'b1, "R10 done held", int'(done), 1);
    end

    // R9 saturation with no reversal
    runStep(6'd12, 2'd2, 1'b1, 4'd1, c0);
    negs(1100);
    check(done == 1'b1, "R9 done on saturation", int'(done), 1);
    check(overflow == 1'b1, "R9 overflow set", int'(overflow), 1);
    check(crossCount == 10'd1023, "R9 count stops at 1023", int'(crossCount), 1023);

    // R10 an accepted start clears done and overflow
    divisorN = 6'd12; fbLevel = 1'b0; startReq = 1'b1;
    negs(1);
    startReq = 1'b0;
    check(done == 1'b0, "R10 restart clears done", int'(done), 0);
    check(overflow == 1'b0, "R10 restart clears overflow", int'(overflow), 0);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule